// File: doc/BRIEF.md
# Byte-Lane Memory Access Interface

This block connects a 16-bit processor datapath to a memory that stores 16-bit words and is addressed in bytes. The datapath presents an address, store data, an access size (word or byte), a direction and an access enable. The block forces the memory address onto a word boundary and picks which byte lane a byte access uses from the address low bit. On a store it raises only the write enables that the access needs. On a load it returns either the whole word or the chosen byte, sign-extended to 16 bits.

A small window of addresses near the top of the address space holds four device registers: keyboard status, keyboard data, display status and display data. An access that falls in this window never reaches the memory. It strobes the matching device select and feeds the device value back through the same byte steering. Device accesses finish in the cycle they are requested. A memory access is registered onto the memory port one cycle after the request and held steady until the memory raises its ready bit. That bit is high for the whole final cycle of the access.

The datapath keeps its request asserted until `acc_done` is seen. Read data is valid in that same cycle.

Top module: `byte_lane_mem_if`

## Requirements
- R1: `mem_addr` always equals the request address with bit 0 cleared. A word access at an odd address is serviced at the word below it, with no error.
- R2: A byte load returns the upper byte [15:8] when address bit 0 is 1 and the lower byte [7:0] when it is 0. The chosen byte sits in [7:0] and its bit 7 is copied into [15:8].
- R3: A word load returns the memory word unchanged.
- R4: A word store raises both write enables and drives `acc_wdata` unchanged onto `mem_wdata`. `mem_we[1]` enables the upper byte and `mem_we[0]` enables the lower byte.
- R5: A byte store drives `acc_wdata[7:0]` into both halves of `mem_wdata` and raises only the enable of the chosen lane. The other byte of the memory word is left unchanged.
- R6: Addresses 0xFE00, 0xFE02, 0xFE04 and 0xFE06 (bit 0 ignored) select keyboard status, keyboard data, display status and display data. These map to bits 0, 1, 2 and 3 of `dev_rd_o` and `dev_wr_o`. A read returns the matching device input. `mem_en` stays low for any device access.
- R7: A device access raises `acc_done` in the cycle it is requested. A memory access raises `mem_en` from the cycle after the request.
- R8: While a memory access waits, the memory-side outputs (`mem_addr`, `mem_we`, `mem_wdata`, `mem_wr`) hold the values captured at launch, whatever the request inputs do.
- R9: For a memory access, `acc_done` is high exactly in the cycle `mem_ready` is high, and `acc_rdata` is valid then. With a five-cycle memory, that is the fifth cycle of `mem_en`, and `mem_en` drops in the next cycle.
- R10: After reset with no request, `mem_en`, `mem_we`, `acc_done`, `dev_rd_o` and `dev_wr_o` are all zero.
- R11: A device byte write drives the store byte into both halves of `dev_wdata`. A device byte read is steered and sign-extended as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Access request (memory or device) |
| acc_wr | input | 1 | 1 = store, 0 = load |
| acc_word | input | 1 | 1 = word access, 0 = byte access |
| acc_addr | input | 16 | Byte address |
| acc_wdata | input | 16 | Store data |
| acc_rdata | output | 16 | Load result (word or sign-extended byte) |
| acc_done | output | 1 | Access completes this cycle |
| mem_addr | output | 16 | Word-aligned memory address |
| mem_en | output | 1 | Memory access active |
| mem_wr | output | 1 | Memory direction, 1 = write |
| mem_we | output | 2 | Byte write enables, bit 1 upper, bit 0 lower |
| mem_wdata | output | 16 | Lane-steered memory write data |
| mem_rdata | input | 16 | Memory read word |
| mem_ready | input | 1 | Memory completes in this cycle |
| kbd_stat_i | input | 16 | Keyboard status register value |
| kbd_data_i | input | 16 | Keyboard data register value |
| dsp_stat_i | input | 16 | Display status register value |
| dsp_data_i | input | 16 | Display data register value |
| dev_rd_o | output | 4 | One-hot device read strobe |
| dev_wr_o | output | 4 | One-hot device write strobe |
| dev_wdata | output | 16 | Lane-steered device write data |

## Verification
The hardest condition to reach from the ports is a request whose inputs change while a memory access is still waiting for ready. A well-behaved datapath never does this, so it only shows up if the register stage at the memory port is faulty. The stimulus launches a word load and, on every wait cycle, moves the address into a different word, flips the size to byte and changes the store data. It checks that the memory-side outputs hold each cycle and that the value returned is the word at the original address. The byte-lane checks go through a behavioural memory with a five-cycle latency. Each byte store is followed by a word read-back, which shows that the untouched byte survived.

// File: rtl/blm_pkg.sv
package blm_pkg;

  // Sequencer states for the memory side
  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_BUSY = 1'b1
  } seq_state_e;

  // Device register count and slot order (slot = address bits above the lane bits)
  localparam int NDEV          = 4;
  localparam int DEV_KBD_STAT  = 0;
  localparam int DEV_KBD_DATA  = 1;
  localparam int DEV_DSP_STAT  = 2;
  localparam int DEV_DSP_DATA  = 3;

endpackage

// File: rtl/blm_addr_map.sv
module blm_addr_map #(
  parameter int            AW       = 16,
  parameter int            LANES    = 2,
  parameter int            NDEV     = 4,
  parameter logic [AW-1:0] DEV_BASE = 16'hFE00
) (
  input  logic [AW-1:0]              addr,
  output logic [AW-1:0]              word_addr,
  output logic [$clog2(LANES)-1:0]   lane,
  output logic                       is_dev,
  output logic [NDEV-1:0]            dev_sel
);
  localparam int LSB_W = $clog2(LANES);
  localparam int DEV_W = $clog2(NDEV);
  localparam int REG_LO = LSB_W + DEV_W;

  logic [DEV_W-1:0] slot;

  // drop lane bits to reach the containing word
  assign word_addr = {addr[AW-1:LSB_W], {LSB_W{1'b0}}};
  assign lane      = addr[LSB_W-1:0];
  assign slot      = addr[REG_LO-1:LSB_W];
  assign is_dev    = (addr[AW-1:REG_LO] == DEV_BASE[AW-1:REG_LO]);

  for (genvar d = 0; d < NDEV; d++) begin : g_dev_sel
    assign dev_sel[d] = is_dev && (slot == DEV_W'(d));
  end

endmodule

// File: rtl/blm_lane_wr.sv
module blm_lane_wr #(
  parameter int DW    = 16,
  parameter int BW    = 8,
  parameter int LANES = 2
) (
  input  logic [DW-1:0]             wdata,
  input  logic                      word,
  input  logic                      wr,
  input  logic [$clog2(LANES)-1:0]  lane,
  output logic [LANES-1:0]          we,
  output logic [DW-1:0]             lane_data
);
  localparam int LSB_W = $clog2(LANES);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    // a byte store copies the low byte into every lane; the enable picks the target
    assign lane_data[l*BW +: BW] = word ? wdata[l*BW +: BW] : wdata[BW-1:0];
    assign we[l]                 = wr && (word || (lane == LSB_W'(l)));
  end

endmodule

// File: rtl/blm_lane_rd.sv
module blm_lane_rd #(
  parameter int DW    = 16,
  parameter int BW    = 8,
  parameter int LANES = 2
) (
  input  logic [DW-1:0]             word_in,
  input  logic                      word,
  input  logic [$clog2(LANES)-1:0]  lane,
  output logic [DW-1:0]             data
);
  logic [BW-1:0] lane_bytes [LANES];
  logic [BW-1:0] picked;

  for (genvar l = 0; l < LANES; l++) begin : g_split
    assign lane_bytes[l] = word_in[l*BW +: BW];
  end

  assign picked = lane_bytes[lane];
  assign data   = word ? word_in : {{(DW-BW){picked[BW-1]}}, picked};

endmodule

// File: rtl/blm_seq.sv
module blm_seq
  import blm_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int LANES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      launch,
  input  logic                      ready,
  input  logic [AW-1:0]             nxt_addr,
  input  logic                      nxt_wr,
  input  logic                      nxt_word,
  input  logic [$clog2(LANES)-1:0]  nxt_lane,
  input  logic [LANES-1:0]          nxt_we,
  input  logic [DW-1:0]             nxt_wdata,
  output logic                      busy,
  output logic [AW-1:0]             mem_addr,
  output logic                      mem_wr,
  output logic [LANES-1:0]          mem_we,
  output logic [DW-1:0]             mem_wdata,
  output logic                      cap_word,
  output logic [$clog2(LANES)-1:0]  cap_lane
);
  localparam int LSB_W = $clog2(LANES);

  seq_state_e       state_q, state_d;
  logic             load, clear;
  logic [LANES-1:0] we_q, we_d;

  assign load  = (state_q == SEQ_IDLE) && launch;
  assign clear = (state_q == SEQ_BUSY) && ready;

  always_comb begin
    state_d = state_q;
    case (state_q)
      SEQ_IDLE: if (launch) state_d = SEQ_BUSY;
      SEQ_BUSY: if (ready)  state_d = SEQ_IDLE;
      default:              state_d = SEQ_IDLE;
    endcase
  end

  always_comb begin
    we_d = we_q;
    if (load)       we_d = nxt_we;
    else if (clear) we_d = '0;
  end

  // control registers: reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      we_q    <= '0;
    end else begin
      state_q <= state_d;
      we_q    <= we_d;
    end
  end

  // request capture: enabled by load only, no reset needed
  logic [AW-1:0]    addr_q;
  logic             wr_q;
  logic             word_q;
  logic [LSB_W-1:0] lane_q;
  logic [DW-1:0]    wdata_q;

  always_ff @(posedge clk) begin
    if (load) begin
      addr_q  <= nxt_addr;
      wr_q    <= nxt_wr;
      word_q  <= nxt_word;
      lane_q  <= nxt_lane;
      wdata_q <= nxt_wdata;
    end
  end

  assign busy      = (state_q == SEQ_BUSY);
  assign mem_addr  = addr_q;
  assign mem_wr    = busy && wr_q;
  assign mem_we    = we_q;
  assign mem_wdata = wdata_q;
  assign cap_word  = word_q;
  assign cap_lane  = lane_q;

endmodule

// File: rtl/byte_lane_mem_if.sv
module byte_lane_mem_if
  import blm_pkg::*;
#(
  parameter int            AW       = 16,
  parameter int            DW       = 16,
  parameter int            BW       = 8,
  parameter logic [AW-1:0] DEV_BASE = 16'hFE00
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_en,
  input  logic                acc_wr,
  input  logic                acc_word,
  input  logic [AW-1:0]       acc_addr,
  input  logic [DW-1:0]       acc_wdata,
  output logic [DW-1:0]       acc_rdata,
  output logic                acc_done,
  output logic [AW-1:0]       mem_addr,
  output logic                mem_en,
  output logic                mem_wr,
  output logic [DW/BW-1:0]    mem_we,
  output logic [DW-1:0]       mem_wdata,
  input  logic [DW-1:0]       mem_rdata,
  input  logic                mem_ready,
  input  logic [DW-1:0]       kbd_stat_i,
  input  logic [DW-1:0]       kbd_data_i,
  input  logic [DW-1:0]       dsp_stat_i,
  input  logic [DW-1:0]       dsp_data_i,
  output logic [NDEV-1:0]     dev_rd_o,
  output logic [NDEV-1:0]     dev_wr_o,
  output logic [DW-1:0]       dev_wdata
);
  localparam int LANES = DW / BW;
  localparam int LSB_W = $clog2(LANES);

  logic [AW-1:0]    word_addr;
  logic [LSB_W-1:0] lane;
  logic             is_dev;
  logic [NDEV-1:0]  dev_sel;
  logic [LANES-1:0] req_we;
  logic [DW-1:0]    req_lane_data;
  logic             busy;
  logic             cap_word;
  logic [LSB_W-1:0] cap_lane;
  logic [DW-1:0]    dev_in [NDEV];
  logic [DW-1:0]    dev_word;
  logic [DW-1:0]    rd_src;
  logic             rd_word;
  logic [LSB_W-1:0] rd_lane;
  logic             dev_req;

  blm_addr_map #(
    .AW(AW), .LANES(LANES), .NDEV(NDEV), .DEV_BASE(DEV_BASE)
  ) i_addr_map (
    .addr      (acc_addr),
    .word_addr (word_addr),
    .lane      (lane),
    .is_dev    (is_dev),
    .dev_sel   (dev_sel)
  );

  blm_lane_wr #(
    .DW(DW), .BW(BW), .LANES(LANES)
  ) i_lane_wr (
    .wdata     (acc_wdata),
    .word      (acc_word),
    .wr        (acc_wr),
    .lane      (lane),
    .we        (req_we),
    .lane_data (req_lane_data)
  );

  blm_seq #(
    .AW(AW), .DW(DW), .LANES(LANES)
  ) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (acc_en && !is_dev),
    .ready     (mem_ready),
    .nxt_addr  (word_addr),
    .nxt_wr    (acc_wr),
    .nxt_word  (acc_word),
    .nxt_lane  (lane),
    .nxt_we    (req_we),
    .nxt_wdata (req_lane_data),
    .busy      (busy),
    .mem_addr  (mem_addr),
    .mem_wr    (mem_wr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .cap_word  (cap_word),
    .cap_lane  (cap_lane)
  );

  // device register read mux
  assign dev_in[DEV_KBD_STAT] = kbd_stat_i;
  assign dev_in[DEV_KBD_DATA] = kbd_data_i;
  assign dev_in[DEV_DSP_STAT] = dsp_stat_i;
  assign dev_in[DEV_DSP_DATA] = dsp_data_i;

  always_comb begin
    dev_word = '0;
    for (int d = 0; d < NDEV; d++) begin
      if (dev_sel[d]) dev_word = dev_word | dev_in[d];
    end
  end

  // device accesses are only taken while the memory side is idle
  assign dev_req   = acc_en && !busy && is_dev;
  assign dev_rd_o  = (dev_req && !acc_wr) ? dev_sel : '0;
  assign dev_wr_o  = (dev_req &&  acc_wr) ? dev_sel : '0;
  assign dev_wdata = req_lane_data;

  // one read steering path shared by memory and device returns
  assign rd_src  = busy ? mem_rdata : dev_word;
  assign rd_word = busy ? cap_word  : acc_word;
  assign rd_lane = busy ? cap_lane  : lane;

  blm_lane_rd #(
    .DW(DW), .BW(BW), .LANES(LANES)
  ) i_lane_rd (
    .word_in (rd_src),
    .word    (rd_word),
    .lane    (rd_lane),
    .data    (acc_rdata)
  );

  assign mem_en   = busy;
  assign acc_done = busy ? mem_ready : dev_req;

endmodule

// File: rtl/blm_chk.sv
module blm_chk #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int BW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_en,
  input logic              acc_done,
  input logic [AW-1:0]     mem_addr,
  input logic              mem_en,
  input logic              mem_wr,
  input logic [DW/BW-1:0]  mem_we,
  input logic [DW-1:0]     mem_wdata,
  input logic              mem_ready,
  input logic [3:0]        dev_rd_o,
  input logic [3:0]        dev_wr_o
);
  localparam int LANES = DW / BW;

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (mem_addr[0] == 1'b0)); // R1

  AST_WE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (|mem_we) |-> (mem_en && mem_wr)); // R4

  AST_WRITE_HAS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_wr) |-> (mem_we != '0)); // R5

  AST_BYTE_REPLICATED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_wr && $onehot(mem_we)) |-> (mem_wdata[2*BW-1:BW] == mem_wdata[BW-1:0])); // R5

  AST_DEV_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_rd_o | dev_wr_o)); // R6

  AST_DEV_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (|(dev_rd_o | dev_wr_o)) |-> !mem_en); // R6

  AST_HOLD_WHILE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_ready) |=> (mem_en && $stable(mem_addr) && $stable(mem_we)
                                && $stable(mem_wdata) && $stable(mem_wr))); // R8

  AST_DONE_AT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && acc_done) |-> mem_ready); // R9

  AST_RELEASE_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_ready) |=> !mem_en); // R9

  AST_DONE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_done && !mem_en) |-> acc_en); // R7

endmodule

bind byte_lane_mem_if blm_chk #(.AW(AW), .DW(DW), .BW(BW)) i_blm_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_en    (acc_en),
  .acc_done  (acc_done),
  .mem_addr  (mem_addr),
  .mem_en    (mem_en),
  .mem_wr    (mem_wr),
  .mem_we    (mem_we),
  .mem_wdata (mem_wdata),
  .mem_ready (mem_ready),
  .dev_rd_o  (dev_rd_o),
  .dev_wr_o  (dev_wr_o)
);

// File: tb/test_byte_lane_mem_if.sv
`timescale 1ns/1ps
module test_byte_lane_mem_if;

  localparam int MEM_LAT = 5;

  logic        clk;
  logic        rst_n;
  logic        acc_en, acc_wr, acc_word;
  logic [15:0] acc_addr, acc_wdata;
  logic [15:0] acc_rdata;
  logic        acc_done;
  logic [15:0] mem_addr;
  logic        mem_en, mem_wr;
  logic [1:0]  mem_we;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic        mem_ready;
  logic [15:0] kbd_stat_i, kbd_data_i, dsp_stat_i, dsp_data_i;
  logic [3:0]  dev_rd_o, dev_wr_o;
  logic [15:0] dev_wdata;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;
  bit finished = 0;

  byte_lane_mem_if i_byte_lane_mem_if (
    .clk(clk), .rst_n(rst_n),
    .acc_en(acc_en), .acc_wr(acc_wr), .acc_word(acc_word),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .acc_done(acc_done),
    .mem_addr(mem_addr), .mem_en(mem_en), .mem_wr(mem_wr),
    .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .kbd_stat_i(kbd_stat_i), .kbd_data_i(kbd_data_i),
    .dsp_stat_i(dsp_stat_i), .dsp_data_i(dsp_data_i),
    .dev_rd_o(dev_rd_o), .dev_wr_o(dev_wr_o), .dev_wdata(dev_wdata)
  );

  // 125 MHz
  initial clk = 1'b0;
  always #4 clk = ~clk;

  // behavioural memory: ready high in the fifth cycle of mem_en
  logic [15:0] mem_arr [0:255];
  int          lat_cnt;
  assign mem_ready = mem_en && (lat_cnt == MEM_LAT - 1);
  assign mem_rdata = mem_arr[mem_addr[8:1]];

  always @(posedge clk) begin
    if (!mem_en || mem_ready) lat_cnt <= 0;
    else                      lat_cnt <= lat_cnt + 1;
    if (mem_en && mem_ready) begin
      if (mem_we[1]) mem_arr[mem_addr[8:1]][15:8] <= mem_wdata[15:8];
      if (mem_we[0]) mem_arr[mem_addr[8:1]][7:0]  <= mem_wdata[7:0];
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cycles);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // one access; returns data, wait cycles and memory-side view at first wait cycle
  task automatic run_access(input logic wr, input logic word, input logic [15:0] addr,
                            input logic [15:0] wd, output logic [15:0] rd, output int lat,
                            output logic [15:0] a_seen, output logic [1:0] we_seen,
                            output logic [15:0] wd_seen, output logic en_seen);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = wr; acc_word = word; acc_addr = addr; acc_wdata = wd;
    #1;
    lat = 0;
    a_seen = '0; we_seen = '0; wd_seen = '0; en_seen = mem_en;
    while (!acc_done && lat < 40) begin
      @(negedge clk);
      #1;
      lat++;
      if (lat == 1) begin
        a_seen = mem_addr; we_seen = mem_we; wd_seen = mem_wdata; en_seen = mem_en;
      end
    end
    rd = acc_rdata;
    acc_en = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 mem_en", mem_en, 0);
    chk("R10 mem_we", mem_we, 0);
    chk("R10 acc_done", acc_done, 0);
    chk("R10 dev strobes", {dev_rd_o, dev_wr_o}, 0);
  endtask

  task automatic t_word();
    logic [15:0] rd, a, wd; logic [1:0] we; logic en; int lat;
    run_access(1, 1, 16'h0010, 16'hA55A, rd, lat, a, we, wd, en);
    chk("R4 word store enables", we, 2'b11);
    chk("R4 word store data", wd, 16'hA55A);
    chk("R7 mem_en after launch", en, 1);
    chk("R9 store latency", lat, MEM_LAT);
    run_access(0, 1, 16'h0010, 16'h0000, rd, lat, a, we, wd, en);
    chk("R3 word load", rd, 16'hA55A);
    chk("R9 load latency", lat, MEM_LAT);
    chk("R1 aligned even", a, 16'h0010);
    @(negedge clk); #1;
    chk("R9 mem_en released", mem_en, 0);
  endtask

  task automatic t_byte_load();
    logic [15:0] rd, a, wd; logic [1:0] we; logic en; int lat;
    run_access(1, 1, 16'h0020, 16'h8C35, rd, lat, a, we, wd, en);
    run_access(1, 1, 16'h0022, 16'h7FF0, rd, lat, a, we, wd, en);
    run_access(0, 0, 16'h0020, 16'h0, rd, lat, a, we, wd, en);
    chk("R2 low lane positive", rd, 16'h0035);
    run_access(0, 0, 16'h0021, 16'h0, rd, lat, a, we, wd, en);
    chk("R2 high lane negative", rd, 16'hFF8C);
    chk("R1 byte odd aligned", a, 16'h0020);
    run_access(0, 0, 16'h0022, 16'h0, rd, lat, a, we, wd, en);
    chk("R2 low lane negative", rd, 16'hFFF0);
    run_access(0, 0, 16'h0023, 16'h0, rd, lat, a, we, wd, en);
    chk("R2 high lane positive", rd, 16'h007F);
  endtask

  task automatic t_byte_store();
    logic [15:0] rd, a, wd; logic [1:0] we; logic en; int lat;
    run_access(1, 1, 16'h0030, 16'h1234, rd, lat, a, we, wd, en);
    run_access(1, 0, 16'h0031, 16'h12C4, rd, lat, a, we, wd, en);
    chk("R5 upper enable only", we, 2'b10);
    chk("R5 replicated data", wd, 16'hC4C4);
    run_access(0, 1, 16'h0030, 16'h0, rd, lat, a, we, wd, en);
    chk("R5 upper byte written, lower kept", rd, 16'hC434);
    run_access(1, 0, 16'h0030, 16'hFF99, rd, lat, a, we, wd, en);
    chk("R5 lower enable only", we, 2'b01);
    chk("R5 replicated data low", wd, 16'h9999);
    run_access(0, 1, 16'h0030, 16'h0, rd, lat, a, we, wd, en);
    chk("R5 lower byte written, upper kept", rd, 16'hC499);
  endtask

  task automatic t_odd_word();
    logic [15:0] rd, a, wd; logic [1:0] we; logic en; int lat;
    run_access(1, 1, 16'h0041, 16'hBEEF, rd, lat, a, we, wd, en);
    chk("R1 odd word address aligned", a, 16'h0040);
    chk("R1 odd word both enables", we, 2'b11);
    run_access(0, 1, 16'h0040, 16'h0, rd, lat, a, we, wd, en);
    chk("R1 odd word landed at word below", rd, 16'hBEEF);
  endtask

  task automatic t_device();
    logic [15:0] rd, a, wd; logic [1:0] we; logic en; int lat;
    logic [15:0] addrs [4];
    logic [15:0] vals  [4];
    addrs = '{16'hFE00, 16'hFE02, 16'hFE04, 16'hFE06};
    vals  = '{16'h8000, 16'h0061, 16'h80C3, 16'h1357};
    for (int d = 0; d < 4; d++) begin
      @(negedge clk);
      acc_en = 1; acc_wr = 0; acc_word = 1; acc_addr = addrs[d]; #1;
      chk("R7 device done same cycle", acc_done, 1);
      chk("R6 device read strobe", dev_rd_o, 4'b0001 << d);
      chk("R6 device read value", acc_rdata, vals[d]);
      chk("R6 no memory enable", mem_en, 0);
      acc_en = 0;
      @(negedge clk); #1;
      chk("R6 no memory launched", mem_en, 0);
    end
    run_access(0, 1, 16'hFE03, 16'h0, rd, lat, a, we, wd, en);
    chk("R6 odd device address maps down", rd, 16'h0061);
    chk("R7 device latency zero", lat, 0);
    run_access(0, 0, 16'hFE05, 16'h0, rd, lat, a, we, wd, en);
    chk("R11 device byte read sign-extended", rd, 16'hFF80);
    run_access(0, 0, 16'hFE04, 16'h0, rd, lat, a, we, wd, en);
    chk("R11 device low byte read", rd, 16'hFFC3);
    @(negedge clk);
    acc_en = 1; acc_wr = 1; acc_word = 1; acc_addr = 16'hFE06; acc_wdata = 16'h2468; #1;
    chk("R6 device write strobe", dev_wr_o, 4'b1000);
    chk("R6 device word write data", dev_wdata, 16'h2468);
    chk("R6 device write no memory", mem_en, 0);
    acc_word = 0; acc_addr = 16'hFE07; acc_wdata = 16'h0041; #1;
    chk("R11 device byte write replicated", dev_wdata, 16'h4141);
    acc_en = 0;
    @(negedge clk); #1;
    chk("R6 memory idle after device write", mem_en, 0);
  endtask

  task automatic t_hold();
    int lat;
    @(negedge clk);
    acc_en = 1; acc_wr = 0; acc_word = 1; acc_addr = 16'h0010; acc_wdata = 16'h0; #1;
    lat = 0;
    while (!acc_done && lat < 40) begin
      @(negedge clk); #1;
      lat++;
      chk("R8 address held", mem_addr, 16'h0010);
      chk("R8 enables held", mem_we, 2'b00);
      chk("R8 direction held", mem_wr, 0);
      acc_addr = 16'h0051 + 16'(lat); acc_word = 0; acc_wr = 1; acc_wdata = 16'hFFFF; #1;
    end
    chk("R8 result from original request", acc_rdata, 16'hA55A);
    chk("R9 hold latency", lat, MEM_LAT);
    acc_en = 0; acc_wr = 0;
  endtask

  initial begin
    rst_n = 0;
    acc_en = 0; acc_wr = 0; acc_word = 0; acc_addr = '0; acc_wdata = '0;
    kbd_stat_i = 16'h8000; kbd_data_i = 16'h0061;
    dsp_stat_i = 16'h80C3; dsp_data_i = 16'h1357;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    t_reset();
    t_word();
    t_byte_load();
    t_byte_store();
    t_odd_word();
    t_device();
    t_hold();
    repeat (3) @(negedge clk);
    finished = 1;
    summary();
    $finish;
  end

endmodule